// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Ten sources feed it: seven external request lines, two timer overflows and one serial channel. Each source owns a request flag. The flag is raised whenever the source reports its condition, and this happens whether or not the source is enabled. Once per machine cycle the controller takes a snapshot of the flags, masked by a global enable and a per-source enable. At an instruction boundary it picks one winner from that snapshot and, on the next cycle, tells the core to force a call to the winner's vector address.

There are two priority levels. Each source chooses its level with one priority bit. A two-bit in-service record tracks which levels are currently being served. A running handler can be interrupted only by a request at a strictly higher level. A return from interrupt retires the highest active level. The acknowledge is held back for one instruction when that instruction is a return from interrupt, or when it writes any enable or priority register. Together, these rules keep the core from being interrupted while its interrupt context is changing.

Top module: `irqArbiter`

## Requirements
- R1: After reset, `ackOut`, `flags`, `inSvc` and `vecOut` are all zero. A one-cycle pulse on `srcReq[i]` sets `flags[i]` on that clock edge, whatever the state of the enables.
- R2: While the global enable (bit 7 of the write at address 0) is 0, no acknowledge is issued for any source.
- R3: Per-source enables: a write at address 0 sets bits 6..0 for sources 0..6, and a write at address 1 sets bits 2..0 for sources 7..9. A 0 blocks that source.
- R4: The masked flags are captured only on a clock with `mcStrobe` high. Grant decisions use the most recent capture, so a flag that arrives after the last strobe cannot be acknowledged until the next strobe.
- R5: When `instrEnd` is high and a permitted winner exists, `ackOut` is high for exactly the following cycle. In that cycle `vecOut` = 0x0003 + 8*index, and `vecOut` then holds that value. Source index order: 0 = ext0, 1 = timer0, 2 = ext1, 3 = timer1, 4 = serial, 5..9 = ext2..ext6.
- R6: Priority bits are set by a write at address 2 (bits 7..0 for sources 0..7) and a write at address 3 (bits 1..0 for sources 8..9); 1 means the high level. Any high-level request beats every low-level request. Within one level, the lower index wins.
- R7: An acknowledge sets the in-service bit of the winner's level (`inSvc` bit 0 for low, bit 1 for high). A request is granted only if its level is strictly above every active in-service level.
- R8: No acknowledge follows an `instrEnd` when `curIsReti` is high in that cycle. None follows either when an address 0..3 write happened at any point since the previous `instrEnd`, including the same cycle.
- R9: A pulse on `retiIn` clears `inSvc[1]` if it is set, and otherwise clears `inSvc[0]`.
- R10: An acknowledge clears the winner's flag on the same edge that raises `ackOut`, except for the serial source (index 4), whose flag stays set. A `srcReq` pulse on that same edge leaves the flag set.
- R11: A write at address 4 clears `flags[7:0]` where the data bit is 1. A write at address 5 does the same for `flags[9:8]` using data bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcStrobe | input | 1 | Machine-cycle strobe; captures masked flags |
| instrEnd | input | 1 | Instruction boundary; arbitration point |
| curIsReti | input | 1 | Instruction now completing is a return from interrupt |
| retiIn | input | 1 | Return from interrupt executed; retires one level |
| regWrEn | input | 1 | Control register write strobe |
| regWrAddr | input | 3 | Control register address |
| regWrData | input | 8 | Control register write data |
| srcReq | input | 10 | Per-source condition pulses, index order as in R5 |
| ackOut | output | 1 | One-cycle forced-call request to the core |
| vecOut | output | 16 | Vector address of the last acknowledged source |
| inSvc | output | 2 | In-service levels: bit 1 high, bit 0 low |
| flags | output | 10 | Current request flags |

## Verification
Several rules are checked by assertions on every cycle. A flag rises after its request pulse. A capture with the global enable off is empty, and a capture never holds a disabled source. The capture stays unchanged between strobes unless a grant occurs. No acknowledge follows a return-from-interrupt instruction or a blocked register write, and none occurs while the high level is in service. Every acknowledge comes after an instruction boundary and leaves a level in service. Only the bench's scenarios, checked against a cycle-level reference model, can show the rest: the vector values, the tie order within a level, high-level preemption of a low handler, a flag that is set again during its own grant, the serial flag surviving an acknowledge, and the software flag clear.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int NSRC   = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int VEC_W  = 16;

  localparam logic [ADDR_W-1:0] A_EN_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRI_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRI_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR_HI = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic            grant;
    logic [NSRC-1:0] grantMask;
  } ctlStrobe_t;
endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_SRC    = NSRC,
  parameter int DW         = DATA_W,
  parameter int AW         = ADDR_W,
  parameter int SERIAL_IDX = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mcStrobe,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regWrAddr,
  input  logic [DW-1:0]      regWrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  ctlStrobe_t         strb,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic [NUM_SRC-1:0] sampledOut,
  output logic [NUM_SRC-1:0] prioOut
);
  localparam int EN_HI_W  = NUM_SRC - (DW - 1);
  localparam int PRI_HI_W = NUM_SRC - DW;
  localparam int CLR_HI_W = NUM_SRC - DW;

  logic [DW-1:0]       enLoQ;
  logic [EN_HI_W-1:0]  enHiQ;
  logic [DW-1:0]       priLoQ;
  logic [PRI_HI_W-1:0] priHiQ;
  logic [NUM_SRC-1:0]  flagsQ;
  logic [NUM_SRC-1:0]  sampledQ;
  logic [NUM_SRC-1:0]  swClr;
  logic [NUM_SRC-1:0]  enVec;
  logic                globEn;

  // control register bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enLoQ  <= '0;
      enHiQ  <= '0;
      priLoQ <= '0;
      priHiQ <= '0;
    end else if (regWrEn) begin
      case (regWrAddr)
        A_EN_LO:  enLoQ  <= regWrData;
        A_EN_HI:  enHiQ  <= regWrData[EN_HI_W-1:0];
        A_PRI_LO: priLoQ <= regWrData;
        A_PRI_HI: priHiQ <= regWrData[PRI_HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign globEn  = enLoQ[DW-1];
  assign enVec   = {enHiQ, enLoQ[DW-2:0]};
  assign prioOut = {priHiQ, priLoQ};

  // software write-one-to-clear
  always_comb begin
    swClr = '0;
    if (regWrEn && regWrAddr == A_CLR_LO)
      swClr = {{CLR_HI_W{1'b0}}, regWrData};
    else if (regWrEn && regWrAddr == A_CLR_HI)
      swClr = {regWrData[CLR_HI_W-1:0], {DW{1'b0}}};
  end

  // request flags: set beats every clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    logic ackClr;
    if (g == SERIAL_IDX) begin : gKeep
      assign ackClr = 1'b0;
    end else begin : gAuto
      assign ackClr = strb.grantMask[g];
    end
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[g] <= 1'b0;
      else       flagsQ[g] <= srcReq[g] | (flagsQ[g] & ~ackClr & ~swClr[g]);
    end
  end

  // once-per-machine-cycle capture of masked flags
  always_ff @(posedge clk) begin
    if (!rstN)
      sampledQ <= '0;
    else if (mcStrobe)
      sampledQ <= flagsQ & enVec & {NUM_SRC{globEn}} & ~strb.grantMask;
    else
      sampledQ <= sampledQ & ~strb.grantMask;
  end

  assign flagsOut   = flagsQ;
  assign sampledOut = sampledQ;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|srcReq) |=> ((flagsQ & $past(srcReq)) == $past(srcReq)))
    else $error("flag not set after request"); // R1
  AST_GLOB_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (mcStrobe && !globEn) |=> (sampledQ == '0))
    else $error("capture with global enable off"); // R2
  AST_EN_GATES: assert property (@(posedge clk) disable iff (!rstN)
    mcStrobe |=> ((sampledQ & ~$past(enVec)) == '0))
    else $error("disabled source captured"); // R3
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!mcStrobe && !strb.grant) |=> $stable(sampledQ))
    else $error("capture changed without strobe"); // R4
endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
#(
  parameter int                NUM_SRC  = NSRC,
  parameter int                AW       = ADDR_W,
  parameter int                VW       = VEC_W,
  parameter logic [VW-1:0]     VEC_BASE = 16'h0003,
  parameter int                VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrEnd,
  input  logic               curIsReti,
  input  logic               retiIn,
  input  logic               regWrEn,
  input  logic [AW-1:0]      regWrAddr,
  input  logic [NUM_SRC-1:0] sampledIn,
  input  logic [NUM_SRC-1:0] prioIn,
  output ctlStrobe_t         strb,
  output logic               ackOut,
  output logic [VW-1:0]      vecOut,
  output logic [1:0]         inSvcOut
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] hiHit, loHit;
  logic               winFound, winHigh;
  logic [IDX_W-1:0]   winIdx;
  logic               levelOk, enPriWr, blocked, grant;
  logic               wrSeenQ, ackQ;
  logic [1:0]         inSvcQ, svcNext;
  logic [VW-1:0]      vecQ;

  assign hiHit = sampledIn & prioIn;
  assign loHit = sampledIn & ~prioIn;

  // two-level fixed-order pick
  always_comb begin
    winFound = 1'b0;
    winHigh  = 1'b0;
    winIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!winFound && hiHit[i]) begin
        winFound = 1'b1;
        winHigh  = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!winFound && loHit[i]) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign levelOk = winHigh ? !inSvcQ[1] : (inSvcQ == 2'b00);
  assign enPriWr = regWrEn && (regWrAddr <= A_PRI_HI);
  assign blocked = curIsReti | wrSeenQ | enPriWr;
  assign grant   = instrEnd & winFound & levelOk & ~blocked;

  assign strb.grant     = grant;
  assign strb.grantMask = grant ? (NUM_SRC'(1) << winIdx) : '0;

  // in-service stack: retire the top level, then push the new one
  always_comb begin
    svcNext = inSvcQ;
    if (retiIn) begin
      if (inSvcQ[1]) svcNext[1] = 1'b0;
      else           svcNext[0] = 1'b0;
    end
    if (grant) begin
      if (winHigh) svcNext[1] = 1'b1;
      else         svcNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvcQ  <= 2'b00;
      ackQ    <= 1'b0;
      vecQ    <= '0;
      wrSeenQ <= 1'b0;
    end else begin
      inSvcQ  <= svcNext;
      ackQ    <= grant;
      wrSeenQ <= instrEnd ? 1'b0 : (wrSeenQ | enPriWr);
      if (grant)
        vecQ <= VEC_BASE + VW'(VEC_STEP) * VW'(winIdx);
    end
  end

  assign ackOut   = ackQ;
  assign vecOut   = vecQ;
  assign inSvcOut = inSvcQ;

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> $past(instrEnd))
    else $error("ack without instruction boundary"); // R5
  AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |-> (inSvcQ != 2'b00))
    else $error("ack with no level in service"); // R7
  AST_TOP_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    inSvcQ[1] |=> !ackQ)
    else $error("preempted high level"); // R7
  AST_RETI_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (instrEnd && curIsReti) |=> !ackQ)
    else $error("ack after return instruction"); // R8
  AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (instrEnd && enPriWr) |=> !ackQ)
    else $error("ack after enable/priority write"); // R8
  AST_RETI_POP: assert property (@(posedge clk) disable iff (!rstN)
    (retiIn && inSvcQ[1]) |=> !inSvcQ[1])
    else $error("high level not retired"); // R9
endmodule

// File: rtl/irqArbiter.sv
module irqArbiter
  import irqArbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcStrobe,
  input  logic              instrEnd,
  input  logic              curIsReti,
  input  logic              retiIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [NSRC-1:0]   srcReq,
  output logic              ackOut,
  output logic [VEC_W-1:0]  vecOut,
  output logic [1:0]        inSvc,
  output logic [NSRC-1:0]   flags
);
  ctlStrobe_t      strb;
  logic [NSRC-1:0] sampled, prio;

  irqArbDatapath u_dp (
    .clk, .rstN, .mcStrobe, .regWrEn, .regWrAddr, .regWrData, .srcReq,
    .strb(strb), .flagsOut(flags), .sampledOut(sampled), .prioOut(prio)
  );

  irqArbControl u_ctl (
    .clk, .rstN, .instrEnd, .curIsReti, .retiIn, .regWrEn, .regWrAddr,
    .sampledIn(sampled), .prioIn(prio), .strb(strb),
    .ackOut, .vecOut, .inSvcOut(inSvc)
  );
endmodule

// File: tb/irqArbiter_bench.sv
module irqArbiter_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic mcStrobe = 0, instrEnd = 0, curIsReti = 0, retiIn = 0, regWrEn = 0;
  logic [2:0] regWrAddr = 0;
  logic [7:0] regWrData = 0;
  logic [9:0] srcReq = 0;
  logic ackOut;
  logic [15:0] vecOut;
  logic [1:0] inSvc;
  logic [9:0] flags;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqArbiter u_irqArbiter (.*);

  // behavioural reference model
  bit [9:0] mF, mS, mP, mEn;
  bit mG, mAck, mWr;
  bit [1:0] mSvc;
  int mVec;

  always @(posedge clk) begin
    if (!rstN) begin
      mF = 0; mS = 0; mP = 0; mEn = 0; mG = 0; mAck = 0; mWr = 0; mSvc = 0; mVec = 0;
    end else begin
      int win, wl, cur;
      bit blk, gr, wep;
      bit [9:0] nf, ns;
      win = -1; wl = 0;
      for (int lv = 1; lv >= 0; lv--)
        for (int i = 0; i < 10; i++)
          if (win < 0 && mS[i] && (mP[i] == lv[0])) begin win = i; wl = lv; end
      cur = mSvc[1] ? 1 : (mSvc[0] ? 0 : -1);
      wep = regWrEn && regWrAddr < 4;
      blk = curIsReti || mWr || wep;
      gr = instrEnd && !blk && win >= 0 && wl > cur;
      if (retiIn) begin if (mSvc[1]) mSvc[1] = 0; else mSvc[0] = 0; end
      if (gr) mSvc[wl] = 1;
      nf = mF;
      if (gr && win != 4) nf[win] = 0;
      if (regWrEn && regWrAddr == 4) nf[7:0] = nf[7:0] & ~regWrData;
      if (regWrEn && regWrAddr == 5) nf[9:8] = nf[9:8] & ~regWrData[1:0];
      nf = nf | srcReq;
      ns = mcStrobe ? (mF & mEn & {10{mG}}) : mS;
      if (gr) ns[win] = 0;
      mF = nf; mS = ns;
      if (regWrEn) case (regWrAddr)
        0: begin mG = regWrData[7]; mEn[6:0] = regWrData[6:0]; end
        1: mEn[9:7] = regWrData[2:0];
        2: mP[7:0] = regWrData;
        3: mP[9:8] = regWrData[1:0];
        default: ;
      endcase
      mAck = gr;
      if (gr) mVec = 3 + 8 * win;
      mWr = instrEnd ? 0 : (mWr | wep);
    end
  end

  always @(negedge clk) if (rstN && !done) begin
    tests++;
    if (ackOut !== mAck || vecOut !== 16'(mVec) || inSvc !== mSvc || flags !== mF) begin
      fails++;
      $display("FAIL R5 model: ack=%0b vec=%h svc=%b flags=%b exp ack=%0b vec=%h svc=%b flags=%b",
               ackOut, vecOut, inSvc, flags, mAck, 16'(mVec), mSvc, mF);
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1; regWrAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask
  task automatic pulse(input logic [9:0] r);
    @(negedge clk); srcReq = r;
    @(negedge clk); srcReq = 0;
  endtask
  task automatic endInstr();
    @(negedge clk); instrEnd = 1;
    @(negedge clk); instrEnd = 0;
  endtask
  // strobe cycle then boundary cycle; returns where ack is visible
  task automatic runInstr(input bit reti);
    @(negedge clk); mcStrobe = 1;
    @(negedge clk); mcStrobe = 0; instrEnd = 1; curIsReti = reti; retiIn = reti;
    @(negedge clk); instrEnd = 0; curIsReti = 0; retiIn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset ack", ackOut, 0);
    chk("R1 reset flags", flags, 0);
    chk("R1 reset inSvc", inSvc, 0);
    pulse(10'h001);
    chk("R1 flag set while disabled", flags[0], 1);
    wr(0, 8'h7F); endInstr();
    runInstr(0);
    chk("R2 global off no ack", ackOut, 0);
    wr(0, 8'hFE); endInstr();
    runInstr(0);
    chk("R3 source disabled no ack", ackOut, 0);
    wr(0, 8'h81); endInstr();
    endInstr();
    chk("R4 no ack before capture", ackOut, 0);
    runInstr(0);
    chk("R5 ack ext0", ackOut, 1);
    chk("R5 vec ext0", vecOut, 16'h0003);
    chk("R10 ext0 flag auto-cleared", flags[0], 0);
    chk("R7 low level in service", inSvc, 2'b01);
    pulse(10'h004);
    wr(0, 8'hFF); wr(1, 8'h07); endInstr();
    runInstr(0);
    chk("R7 equal level not preempting", ackOut, 0);
    pulse(10'h002);
    wr(2, 8'h02); endInstr();
    runInstr(0);
    chk("R7 high preempts low", ackOut, 1);
    chk("R7 vec timer0", vecOut, 16'h000B);
    chk("R7 both levels active", inSvc, 2'b11);
    runInstr(1);
    chk("R9 retire high", inSvc, 2'b01);
    runInstr(1);
    chk("R9 retire low", inSvc, 2'b00);
    chk("R8 no ack on return instr", ackOut, 0);
    runInstr(0);
    chk("R8 ack after return instr", vecOut, 16'h0013);
    runInstr(1);
    pulse(10'h00C);
    runInstr(0);
    chk("R6 tie low index wins", vecOut, 16'h0013);
    runInstr(1);
    runInstr(0);
    chk("R6 second of tie", vecOut, 16'h001B);
    runInstr(1);
    wr(3, 8'h02); endInstr();
    pulse(10'h201);
    runInstr(0);
    chk("R6 high level beats order", vecOut, 16'h004B);
    chk("R6 high in service", inSvc, 2'b10);
    runInstr(0);
    chk("R7 low blocked under high", ackOut, 0);
    runInstr(1);
    runInstr(0);
    chk("R7 low after high retired", vecOut, 16'h0003);
    runInstr(1);
    pulse(10'h008);
    wr(2, 8'h02);
    runInstr(0);
    chk("R8 write blocks ack", ackOut, 0);
    runInstr(0);
    chk("R8 ack next instr", vecOut, 16'h001B);
    runInstr(1);
    pulse(10'h010);
    runInstr(0);
    chk("R10 serial acked", vecOut, 16'h0023);
    chk("R10 serial flag kept", flags[4], 1);
    wr(4, 8'h10);
    chk("R11 software clear", flags[4], 0);
    pulse(10'h200);
    wr(5, 8'h02);
    chk("R11 high clear", flags[9], 0);
    runInstr(1);
    pulse(10'h001);
    @(negedge clk); mcStrobe = 1;
    @(negedge clk); mcStrobe = 0; instrEnd = 1; srcReq = 10'h001;
    @(negedge clk); instrEnd = 0; srcReq = 0;
    chk("R10 set wins ack", ackOut, 1);
    chk("R10 set beats clear", flags[0], 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule